// File: doc/BRIEF.md
# Page-Wrapping Word Address Counter

This block keeps the word address pointer of a serial non-volatile byte memory built from 256 pages of 32 bytes, which a 13-bit address covers. The protocol front end loads the pointer from two received address bytes, high byte first. Only the low-byte load moves the pointer, so the address never passes through a half-updated value. After each data byte moves over the bus, the front end sends an increment strobe tagged as read or write. The counter then applies the rollover rule for that direction. A write stays inside its page: the five column bits count and wrap, and the page bits hold. A read walks through the whole array and wraps from the very last byte back to address zero.

The pointer is a register, and it is presented unchanged to both the array and the page write buffer. Between transfers it keeps the last address touched plus one, and a current-address read starts from that value. A write-commit notice from the front end marks the end of a write session. It discards any staged high address byte so that a stale half-load cannot leak into a later transfer. The commit notice never moves the pointer.

Top module: `word_ptr_ctr`

## Requirements
- R1: While `rst` is high at a rising clock edge, `ptr_addr` becomes 0 at that edge.
- R2: A high-byte load (`ld_hi_stb`) leaves `ptr_addr` unchanged. The following low-byte load (`ld_lo_stb`) sets `ptr_addr` to {staged bits 4:0 of the high byte, low byte} at that edge. Bits 7:5 of the high byte are ignored.
- R3: A write increment (`inc_stb` with `inc_is_rd`=0) adds one to `ptr_addr[4:0]` and leaves `ptr_addr[12:5]` unchanged.
- R4: A write increment at column 31 returns the pointer to column 0 of the same page, including on page 255 (0x1FFF goes to 0x1FE0).
- R5: A read increment (`inc_stb` with `inc_is_rd`=1) adds one to the full 13-bit pointer, so it carries into the next page (0x001F goes to 0x0020).
- R6: A read increment at 0x1FFF wraps the pointer to 0x0000.
- R7: In a cycle with no low-byte load and no increment, `ptr_addr` holds its value. This includes cycles that carry `commit_stb` or only `ld_hi_stb`.
- R8: A `commit_stb` clears the staged high part. A low-byte load that follows it with no new high-byte load yields a high part of 0. If `ld_hi_stb` and `commit_stb` come in the same cycle, the new high byte is kept.
- R9: When `ld_lo_stb` and `inc_stb` come in the same cycle, the load wins and the increment is dropped.
- R10: The staged high part stays after a low-byte load. A second low-byte load with no new high byte reuses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_hi_stb | input | 1 | Stage the high address byte from `ld_byte` |
| ld_lo_stb | input | 1 | Load the pointer from the staged high part and `ld_byte` |
| ld_byte | input | 8 | Received address byte |
| inc_stb | input | 1 | One data byte transferred: advance the pointer |
| inc_is_rd | input | 1 | Direction tag for `inc_stb`: 1 = read, 0 = write |
| commit_stb | input | 1 | Write session closed: drop the staged high part |
| ptr_addr | output | 13 | Current word address (registered) |

## Verification
The increment path is driven with both tags from start points chosen to separate the two wrap rules. A mid-page start shows plain counting. Column 31 shows whether a write keeps its page or spills into the next one, and whether a read carries. Address 0x1FFF shows the page-local write wrap against the full-array read wrap. The load path is driven with a high byte whose top bits are set, which exposes any leak of those bits. The bench also covers commit before a lone low load, a load and an increment in the same cycle, and two low loads after a single high load. These show whether staging, clearing and priority are ordered correctly.

// File: rtl/wac_pkg.sv
package wac_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    STEP_WR = 1'b0,
    STEP_RD = 1'b1
  } step_kind_e;
endpackage

// File: rtl/wac_hi_stage.sv
// Holds the upper address bits received in the first address byte
// until the low byte arrives.
module wac_hi_stage #(
  parameter int unsigned HI_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_stb,
  input  logic            clr_stb,
  input  logic [HI_W-1:0] cap_val,
  output logic [HI_W-1:0] stage_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (cap_stb) begin
      stage_q <= cap_val;      // a fresh high byte outranks a commit
    end else if (clr_stb) begin
      stage_q <= '0;
    end
  end
endmodule

// File: rtl/wac_step.sv
// Next-address logic: page-local wrap for writes, whole-array wrap for reads.
module wac_step #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PAGE_W = 5
) (
  input  logic [ADDR_W-1:0]       cur,
  input  wac_pkg::step_kind_e     kind,
  output logic [ADDR_W-1:0]       nxt
);
  logic [ADDR_W-1:0] rd_nxt;
  logic [ADDR_W-1:0] wr_nxt;

  assign rd_nxt = cur + 1'b1;

  generate
    if (PAGE_W >= ADDR_W) begin : g_single_page
      assign wr_nxt = rd_nxt;
    end else begin : g_paged
      logic [PAGE_W-1:0] col_nxt;
      assign col_nxt = cur[PAGE_W-1:0] + 1'b1;
      assign wr_nxt  = {cur[ADDR_W-1:PAGE_W], col_nxt};
    end
  endgenerate

  always_comb begin
    unique case (kind)
      wac_pkg::STEP_RD: nxt = rd_nxt;
      default:          nxt = wr_nxt;
    endcase
  end
endmodule

// File: rtl/word_ptr_ctr.sv
module word_ptr_ctr #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PAGE_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ld_hi_stb,
  input  logic                       ld_lo_stb,
  input  logic [wac_pkg::BYTE_W-1:0] ld_byte,
  input  logic                       inc_stb,
  input  logic                       inc_is_rd,
  input  logic                       commit_stb,
  output logic [ADDR_W-1:0]          ptr_addr
);
  localparam int unsigned BW   = wac_pkg::BYTE_W;
  localparam int unsigned HI_W = ADDR_W - BW;

  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] step_nxt;
  logic [ADDR_W-1:0] ptr_q;

  wac_hi_stage #(.HI_W(HI_W)) u_hi (
    .clk     (clk),
    .rst     (rst),
    .cap_stb (ld_hi_stb),
    .clr_stb (commit_stb),
    .cap_val (ld_byte[HI_W-1:0]),
    .stage_q (hi_q)
  );

  generate
    if (HI_W < BW) begin : g_drop_top
      logic unused_hi_bits;
      assign unused_hi_bits = ^ld_byte[BW-1:HI_W];
    end
  endgenerate

  wac_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
    .cur  (ptr_q),
    .kind (wac_pkg::step_kind_e'(inc_is_rd)),
    .nxt  (step_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (ld_lo_stb) begin
      ptr_q <= {hi_q, ld_byte};
    end else if (inc_stb) begin
      ptr_q <= step_nxt;
    end
  end

  assign ptr_addr = ptr_q;
endmodule

// File: rtl/word_ptr_ctr_chk.sv
module word_ptr_ctr_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PAGE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_hi_stb,
  input logic              ld_lo_stb,
  input logic [7:0]        ld_byte,
  input logic              inc_stb,
  input logic              inc_is_rd,
  input logic              commit_stb,
  input logic [ADDR_W-1:0] ptr_addr
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> ptr_addr == '0);

  // R2
  low_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_lo_stb |=> ptr_addr[7:0] == $past(ld_byte));

  // R3
  wr_page_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_stb && !inc_is_rd && !ld_lo_stb) |=>
      (ptr_addr[ADDR_W-1:PAGE_W] == $past(ptr_addr[ADDR_W-1:PAGE_W])) &&
      (ptr_addr[PAGE_W-1:0] == PAGE_W'($past(ptr_addr[PAGE_W-1:0]) + 1'b1)));

  // R5
  rd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_stb && inc_is_rd && !ld_lo_stb) |=>
      ptr_addr == ADDR_W'($past(ptr_addr) + 1'b1));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_lo_stb && !inc_stb) |=> $stable(ptr_addr));
endmodule

bind word_ptr_ctr word_ptr_ctr_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ld_hi_stb  (ld_hi_stb),
  .ld_lo_stb  (ld_lo_stb),
  .ld_byte    (ld_byte),
  .inc_stb    (inc_stb),
  .inc_is_rd  (inc_is_rd),
  .commit_stb (commit_stb),
  .ptr_addr   (ptr_addr)
);

// File: tb/word_ptr_ctr_test.sv
`timescale 1ns/1ps
module word_ptr_ctr_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_hi_stb, ld_lo_stb, inc_stb, inc_is_rd, commit_stb;
  logic [7:0]  ld_byte;
  logic [12:0] ptr_addr;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  word_ptr_ctr uut (
    .clk(clk), .rst(rst), .ld_hi_stb(ld_hi_stb), .ld_lo_stb(ld_lo_stb),
    .ld_byte(ld_byte), .inc_stb(inc_stb), .inc_is_rd(inc_is_rd),
    .commit_stb(commit_stb), .ptr_addr(ptr_addr)
  );

  task automatic check(input string req, input logic [12:0] exp);
    n_chk++;
    if (ptr_addr !== exp) begin
      n_bad++;
      $display("FAIL %s: ptr_addr=0x%04h expected 0x%04h", req, ptr_addr, exp);
    end
  endtask

  // Drive one cycle of strobes starting at a falling edge; return at the next falling edge.
  task automatic cyc(input logic hi, input logic lo, input logic inc,
                     input logic rd, input logic cm, input logic [7:0] b);
    ld_hi_stb = hi; ld_lo_stb = lo; inc_stb = inc; inc_is_rd = rd;
    commit_stb = cm; ld_byte = b;
    @(negedge clk);
    ld_hi_stb = 0; ld_lo_stb = 0; inc_stb = 0; inc_is_rd = 0; commit_stb = 0;
    ld_byte = 8'h00;
  endtask

  task automatic load(input logic [7:0] h, input logic [7:0] l);
    cyc(1, 0, 0, 0, 0, h);
    cyc(0, 1, 0, 0, 0, l);
  endtask

  task automatic t_reset;
    rst = 1;
    cyc(0, 0, 0, 0, 0, 8'h00);
    cyc(0, 0, 0, 0, 0, 8'h00);
    rst = 0;
    check("R1 reset", 13'h0000);
  endtask

  task automatic t_load;
    cyc(1, 0, 0, 0, 0, 8'hFA);
    check("R2 high byte alone", 13'h0000);
    cyc(0, 1, 0, 0, 0, 8'h3C);
    check("R2 low byte load, top bits ignored", 13'h1A3C);
  endtask

  task automatic t_write_inc;
    load(8'h0A, 8'h1D);
    cyc(0, 0, 1, 0, 0, 8'h00);
    check("R3 write step", 13'h0A1E);
    cyc(0, 0, 1, 0, 0, 8'h00);
    check("R3 write step to col 31", 13'h0A1F);
    cyc(0, 0, 1, 0, 0, 8'h00);
    check("R4 write wrap in page", 13'h0A00);
    cyc(0, 0, 1, 0, 0, 8'h00);
    check("R3 write step after wrap", 13'h0A01);
    load(8'h1F, 8'hFF);
    cyc(0, 0, 1, 0, 0, 8'h00);
    check("R4 write wrap last page", 13'h1FE0);
  endtask

  task automatic t_read_inc;
    load(8'h00, 8'h1F);
    cyc(0, 0, 1, 1, 0, 8'h00);
    check("R5 read crosses page", 13'h0020);
    load(8'h1F, 8'hFF);
    cyc(0, 0, 1, 1, 0, 8'h00);
    check("R6 read wraps array", 13'h0000);
    cyc(0, 0, 1, 1, 0, 8'h00);
    check("R5 read step after wrap", 13'h0001);
  endtask

  task automatic t_hold;
    load(8'h05, 8'h67);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 8'h00);
    check("R7 idle hold", 13'h0567);
    cyc(0, 0, 0, 0, 1, 8'h00);
    check("R7 commit keeps pointer", 13'h0567);
  endtask

  task automatic t_commit_clear;
    cyc(1, 0, 0, 0, 0, 8'h13);
    cyc(0, 0, 0, 0, 1, 8'h00);
    cyc(0, 1, 0, 0, 0, 8'h44);
    check("R8 commit drops staged high", 13'h0044);
    cyc(1, 0, 0, 0, 1, 8'h09);
    cyc(0, 1, 0, 0, 0, 8'h11);
    check("R8 high load beats commit", 13'h0911);
  endtask

  task automatic t_priority_reuse;
    cyc(1, 0, 0, 0, 0, 8'h02);
    cyc(0, 1, 1, 1, 0, 8'h55);
    check("R9 load beats increment", 13'h0255);
    cyc(0, 1, 0, 0, 0, 8'h80);
    check("R10 staged high reused", 13'h0280);
  endtask

  initial begin
    rst = 1; ld_hi_stb = 0; ld_lo_stb = 0; inc_stb = 0; inc_is_rd = 0;
    commit_stb = 0; ld_byte = 8'h00;
    @(negedge clk);
    t_reset();
    t_load();
    t_write_inc();
    t_read_inc();
    t_hold();
    t_commit_clear();
    t_priority_reuse();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule